// File: doc/BRIEF.md
# Power-Off Request Event Aggregator

This block merges many wake and power events into a single power-off request line. An orderly shutdown handler uses that line to run its housekeeping before power is removed. Each general event source has a sticky status bit and two enable bits. Three software-command events (sleep entry, shared-lock release and system-management command) each have a fixed status and enable pair. A separate switch-off button event is qualified by a routing select bit alone.

The request runs in one of two modes. In pulse mode, each newly qualified source produces a one-cycle pulse. In level mode, the request stays high while any qualified source remains. The button event is the exception in level mode: once it has raised the request, only a dedicated clear command releases it. The request output also has an output-enable. That enable stays low after reset until software turns on drive.

Software reaches the block through a plain register port. It has a write strobe with address and data, and a separate combinational read address and read data. The event inputs are one-cycle pulses, sampled on the rising clock edge.

Top module: `pwroff_req_agg`

## Requirements
- R1: A pulse on `gen_evt_i[n]` sets general status bit n. That bit stays set until a write of 1 to bit n at address 0. Address 0 reads back the general status vector, and a simultaneous event wins over the clear.
- R2: General event n qualifies when its status is set and either of two enable bits is set. The first is bit n at address 2, which always counts. The second is bit n at address 1, which counts only while control bit 0 (address 4) is 0.
- R3: The support register at address 3 holds three status/enable pairs:
  - sleep: status bit 0, enable bit 1
  - lock release: status bit 2, enable bit 3
  - system command: status bit 5, enable bit 6

  Writing address 5 with bit 0 set sets the sleep status, and with bit 1 set sets the lock-release status. Any write to address 6 sets the system-command status. Writing address 5 with both bits 0 leaves every status unchanged. In address 3, status bits clear on a write of 1, and the enable bits take the written value.
- R4: A pulse on `sw_evt_i` sets the button status, which is bit 0 at address 7 and clears on a write of 1. The button raises the request only while control bit 1 is 0. Its stored enable, bit 1 at address 7, has no effect on the request.
- R5: In level mode (control bit 2 = 1), `por_req_o` is high one cycle after any general or command source becomes qualified. It stays high while such a source remains qualified, and goes low one cycle after the last one stops being qualified.
- R6: In level mode, a button request stays high after the button status is cleared. Writing control bit 3 = 1 releases it, and the request drops two cycles after that write. Control bit 3 reads 1 in the cycle after the write and 0 after that.
- R7: In pulse mode (control bit 2 = 0), each source that newly becomes qualified gives `por_req_o` high for exactly one cycle, one cycle after qualification. Status bits stay set afterwards.
- R8: After reset, every register is 0, `por_req_o` is 0 and `por_oe_o` is 0. `por_oe_o` follows control bit 4, from the cycle after that bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_evt_i | input | NUM_GEN | General event pulses |
| sw_evt_i | input | 1 | Switch-off button event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| por_req_o | output | 1 | Power-off request, active high |
| por_oe_o | output | 1 | Output enable for the request pin |

## Verification
An event pulse or a write lands in its register on the following edge. The request responds one edge later: two cycles after the stimulus is driven, and one cycle after the driving task returns. The level-clear command is the slow path, because it passes through its one-cycle pending bit first and drops the request two cycles after the write. The output-enable appears in the same cycle the write completes. The driver task turns each of these latencies into an expected entry for a specific cycle number. The monitor samples on the falling edge and compares each entry only in that cycle, reporting any entry whose cycle has passed unchecked.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_GSTS = 3'd0,
    A_GENA = 3'd1,
    A_GENB = 3'd2,
    A_SUP  = 3'd3,
    A_CTL  = 3'd4,
    A_CMD  = 3'd5,
    A_SMI  = 3'd6,
    A_SW   = 3'd7
  } reg_addr_e;

  // support register fields (neighbours decode these positions)
  localparam int unsigned SUP_SLP_S = 0;
  localparam int unsigned SUP_SLP_E = 1;
  localparam int unsigned SUP_LCK_S = 2;
  localparam int unsigned SUP_LCK_E = 3;
  localparam int unsigned SUP_SMI_S = 5;
  localparam int unsigned SUP_SMI_E = 6;

  // control register fields
  localparam int unsigned CTL_GATE  = 0;
  localparam int unsigned CTL_ROUTE = 1;
  localparam int unsigned CTL_LVL   = 2;
  localparam int unsigned CTL_LCLR  = 3;
  localparam int unsigned CTL_DRV   = 4;

  // command strobe fields
  localparam int unsigned CMD_SLP = 0;
  localparam int unsigned CMD_LCK = 1;

  // button register fields
  localparam int unsigned SW_STS = 0;
  localparam int unsigned SW_EN  = 1;

  localparam int unsigned NUM_CMD = 3;
endpackage

// File: rtl/por_gen_bank.sv
module por_gen_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         gate_i,
  input  logic [N-1:0] clr_i,
  input  logic         ld_ena_i,
  input  logic         ld_enb_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] ena_o,
  output logic [N-1:0] enb_o,
  output logic [N-1:0] qual_o
);
  logic [N-1:0] sts_q, ena_q, enb_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sts_q[i] <= 1'b0;
      else if (evt_i[i])  sts_q[i] <= 1'b1;
      else if (clr_i[i])  sts_q[i] <= 1'b0;
    end

    // R1
    gen_sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(evt_i[i]) |-> sts_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q <= '0;
      enb_q <= '0;
    end else begin
      if (ld_ena_i) ena_q <= wdata_i;
      if (ld_enb_i) enb_q <= wdata_i;
    end
  end

  assign sts_o  = sts_q;
  assign ena_o  = ena_q;
  assign enb_o  = enb_q;
  assign qual_o = sts_q & ((ena_q & {N{~gate_i}}) | enb_q);
endmodule

// File: rtl/por_cmd_bank.sv
module por_cmd_bank
  import por_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sup_wr_i,
  input  logic                 cmd_wr_i,
  input  logic                 smi_wr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           sup_o,
  output logic [NUM_CMD-1:0]   qual_o
);
  logic slp_s, slp_e, lck_s, lck_e, smi_s, smi_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slp_s <= 1'b0; slp_e <= 1'b0;
      lck_s <= 1'b0; lck_e <= 1'b0;
      smi_s <= 1'b0; smi_e <= 1'b0;
    end else begin
      if (cmd_wr_i && wdata_i[CMD_SLP])        slp_s <= 1'b1;
      else if (sup_wr_i && wdata_i[SUP_SLP_S]) slp_s <= 1'b0;
      if (cmd_wr_i && wdata_i[CMD_LCK])        lck_s <= 1'b1;
      else if (sup_wr_i && wdata_i[SUP_LCK_S]) lck_s <= 1'b0;
      if (smi_wr_i)                            smi_s <= 1'b1;
      else if (sup_wr_i && wdata_i[SUP_SMI_S]) smi_s <= 1'b0;
      if (sup_wr_i) begin
        slp_e <= wdata_i[SUP_SLP_E];
        lck_e <= wdata_i[SUP_LCK_E];
        smi_e <= wdata_i[SUP_SMI_E];
      end
    end
  end

  always_comb begin
    sup_o            = '0;
    sup_o[SUP_SLP_S] = slp_s;
    sup_o[SUP_SLP_E] = slp_e;
    sup_o[SUP_LCK_S] = lck_s;
    sup_o[SUP_LCK_E] = lck_e;
    sup_o[SUP_SMI_S] = smi_s;
    sup_o[SUP_SMI_E] = smi_e;
  end

  assign qual_o = {smi_s & smi_e, lck_s & lck_e, slp_s & slp_e};

  // R3
  smi_cmd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(smi_wr_i) |-> sup_o[SUP_SMI_S]);

  // R3
  slp_cmd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_wr_i && wdata_i[CMD_SLP]) |-> sup_o[SUP_SLP_S]);
endmodule

// File: rtl/por_out_stage.sv
module por_out_stage #(
  parameter int unsigned NSRC = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            level_i,
  input  logic [NSRC-1:0] src_q_i,
  input  logic            sw_q_i,
  input  logic            clr_i,
  output logic            req_o
);
  logic [NSRC-1:0] src_d;
  logic            sw_d, sw_latch, req_q;
  logic            sw_rise, src_new;

  assign sw_rise = sw_q_i & ~sw_d;
  assign src_new = |(src_q_i & ~src_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_d    <= '0;
      sw_d     <= 1'b0;
      sw_latch <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      src_d <= src_q_i;
      sw_d  <= sw_q_i;
      if (clr_i)                  sw_latch <= 1'b0;
      else if (level_i & sw_rise) sw_latch <= 1'b1;
      if (level_i) req_q <= (|src_q_i) | sw_latch | sw_rise;
      else         req_q <= src_new | sw_rise;
    end
  end

  assign req_o = req_q;

  // R5
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i && (|src_q_i)) |=> req_o);

  // R7
  pulse_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && (src_q_i == src_d) && (sw_q_i == sw_d)) |=> !req_o);

  // R6
  sw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_latch && !clr_i) |=> sw_latch);

  // R6
  sw_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_latch) |-> $past(clr_i));
endmodule

// File: rtl/pwroff_req_agg.sv
module pwroff_req_agg
  import por_pkg::*;
#(
  parameter int unsigned NUM_GEN = 8,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GEN-1:0] gen_evt_i,
  input  logic               sw_evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               por_req_o,
  output logic               por_oe_o
);
  localparam int unsigned NSRC = NUM_GEN + NUM_CMD;

  reg_addr_e waddr, raddr;
  assign waddr = reg_addr_e'(wr_addr_i);
  assign raddr = reg_addr_e'(rd_addr_i);

  logic wr_gsts, wr_gena, wr_genb, wr_sup, wr_ctl, wr_cmd, wr_smi, wr_sw;
  assign wr_gsts = wr_en_i && (waddr == A_GSTS);
  assign wr_gena = wr_en_i && (waddr == A_GENA);
  assign wr_genb = wr_en_i && (waddr == A_GENB);
  assign wr_sup  = wr_en_i && (waddr == A_SUP);
  assign wr_ctl  = wr_en_i && (waddr == A_CTL);
  assign wr_cmd  = wr_en_i && (waddr == A_CMD);
  assign wr_smi  = wr_en_i && (waddr == A_SMI);
  assign wr_sw   = wr_en_i && (waddr == A_SW);

  // control register and self-clearing level-clear command
  logic gate_q, route_q, lvl_q, drv_q, clr_pend;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= 1'b0;
      route_q  <= 1'b0;
      lvl_q    <= 1'b0;
      drv_q    <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      clr_pend <= wr_ctl && wr_data_i[CTL_LCLR];
      if (wr_ctl) begin
        gate_q  <= wr_data_i[CTL_GATE];
        route_q <= wr_data_i[CTL_ROUTE];
        lvl_q   <= wr_data_i[CTL_LVL];
        drv_q   <= wr_data_i[CTL_DRV];
      end
    end
  end

  // switch-off button status and its stored (non-gating) enable
  logic sw_sts, sw_en;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_sts <= 1'b0;
      sw_en  <= 1'b0;
    end else begin
      if (sw_evt_i)                        sw_sts <= 1'b1;
      else if (wr_sw && wr_data_i[SW_STS]) sw_sts <= 1'b0;
      if (wr_sw) sw_en <= wr_data_i[SW_EN];
    end
  end

  logic [NUM_GEN-1:0] gsts, gena, genb, gqual;
  por_gen_bank #(.N(NUM_GEN)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (gen_evt_i),
    .gate_i   (gate_q),
    .clr_i    (wr_gsts ? wr_data_i[NUM_GEN-1:0] : '0),
    .ld_ena_i (wr_gena),
    .ld_enb_i (wr_genb),
    .wdata_i  (wr_data_i[NUM_GEN-1:0]),
    .sts_o    (gsts),
    .ena_o    (gena),
    .enb_o    (genb),
    .qual_o   (gqual)
  );

  logic [7:0]         sup;
  logic [NUM_CMD-1:0] cqual;
  por_cmd_bank u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sup_wr_i (wr_sup),
    .cmd_wr_i (wr_cmd),
    .smi_wr_i (wr_smi),
    .wdata_i  (wr_data_i[7:0]),
    .sup_o    (sup),
    .qual_o   (cqual)
  );

  logic sw_q;
  assign sw_q = sw_sts & ~route_q;

  logic req;
  por_out_stage #(.NSRC(NSRC)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (lvl_q),
    .src_q_i ({cqual, gqual}),
    .sw_q_i  (sw_q),
    .clr_i   (clr_pend),
    .req_o   (req)
  );

  assign por_req_o = req;
  assign por_oe_o  = drv_q;

  always_comb begin
    rd_data_o = '0;
    unique case (raddr)
      A_GSTS: rd_data_o[NUM_GEN-1:0] = gsts;
      A_GENA: rd_data_o[NUM_GEN-1:0] = gena;
      A_GENB: rd_data_o[NUM_GEN-1:0] = genb;
      A_SUP:  rd_data_o[7:0] = sup;
      A_CTL: begin
        rd_data_o[CTL_GATE]  = gate_q;
        rd_data_o[CTL_ROUTE] = route_q;
        rd_data_o[CTL_LVL]   = lvl_q;
        rd_data_o[CTL_LCLR]  = clr_pend;
        rd_data_o[CTL_DRV]   = drv_q;
      end
      A_SW: begin
        rd_data_o[SW_STS] = sw_sts;
        rd_data_o[SW_EN]  = sw_en;
      end
      default: rd_data_o = '0;
    endcase
  end

  // R8
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_oe_o) |-> $past(wr_ctl && wr_data_i[CTL_DRV]));

  // R6
  lclr_selfclear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pend && !(wr_ctl && wr_data_i[CTL_LCLR])) |=> !clr_pend);

  // R4
  sw_route_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_q && !lvl_q && !(|gqual) && !(|cqual) && $stable(route_q)) |=> !por_req_o);
endmodule

// File: tb/pwroff_req_agg_bench.sv
module pwroff_req_agg_bench;
  import por_pkg::*;

  localparam int unsigned NG = 8;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG-1:0] gen_evt = '0;
  logic          sw_evt = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          por_req, por_oe;

  always #4 clk = ~clk;

  pwroff_req_agg #(.NUM_GEN(NG), .DATA_W(DW)) u_pwroff_req_agg (
    .clk_i(clk), .rst_ni(rst_n), .gen_evt_i(gen_evt), .sw_evt_i(sw_evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .por_req_o(por_req), .por_oe_o(por_oe)
  );

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    is_oe;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic expect_out(int d, bit is_oe, bit v, string tag);
    sb.push_back('{cyc + d, is_oe, v, tag});
  endtask

  // monitor: compares scoreboard entries due in this cycle
  always @(negedge clk) begin
    exp_t e;
    logic act;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      act = e.is_oe ? por_oe : por_req;
      nchk++;
      if (e.at < cyc || act !== e.val) begin
        nfail++;
        $display("FAIL %s: %s at cycle %0d actual %b expected %b",
                 e.tag, e.is_oe ? "por_oe" : "por_req", e.at, act, e.val);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(reg_addr_e a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic gev(int idx);
    gen_evt[idx] = 1'b1;
    @(posedge clk); #1;
    gen_evt = '0;
  endtask

  task automatic sev();
    sw_evt = 1'b1;
    @(posedge clk); #1;
    sw_evt = 1'b0;
  endtask

  task automatic rd(reg_addr_e a, logic [7:0] exp_v, string tag);
    rd_addr = a;
    #1;
    nchk++;
    if (rd_data !== exp_v) begin
      nfail++;
      $display("FAIL %s: read addr %0d actual %h expected %h", tag, a, rd_data, exp_v);
    end
    @(posedge clk); #1;
  endtask

  task automatic summary();
    if (sb.size() > 0) begin
      nfail++; nchk++;
      $display("FAIL scoreboard: %0d entries never compared, actual %0d expected 0", sb.size(), sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nfail++; nchk++;
      $display("FAIL watchdog (all requirements): cycle %0d actual running expected done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R8 reset state
    nchk++;
    if (por_req !== 1'b0 || por_oe !== 1'b0) begin
      nfail++;
      $display("FAIL R8: req/oe actual %b%b expected 00", por_req, por_oe);
    end
    for (int a = 0; a < 8; a++) rd(reg_addr_e'(a), 8'h00, "R8");

    // R8 drive enable, level mode on
    wr(A_CTL, 8'h14);
    expect_out(0, 1'b1, 1'b1, "R8");
    expect_out(1, 1'b0, 1'b0, "R8");
    tick(2);

    // R2 second bank, R5 hold, R1 sticky status and clear
    wr(A_GENB, 8'h08);
    gev(3);
    expect_out(1, 1'b0, 1'b1, "R2");
    expect_out(2, 1'b0, 1'b1, "R5");
    expect_out(3, 1'b0, 1'b1, "R5");
    rd(A_GSTS, 8'h08, "R1");
    tick(3);
    wr(A_GSTS, 8'h08);
    expect_out(1, 1'b0, 1'b0, "R5");
    expect_out(2, 1'b0, 1'b0, "R1");
    rd(A_GSTS, 8'h00, "R1");
    tick(2);

    // R2 first bank gated by control bit 0
    wr(A_GENB, 8'h00);
    wr(A_GENA, 8'h01);
    wr(A_CTL, 8'h15);
    gev(0);
    expect_out(1, 1'b0, 1'b0, "R2");
    expect_out(2, 1'b0, 1'b0, "R2");
    tick(3);
    wr(A_CTL, 8'h14);
    expect_out(1, 1'b0, 1'b1, "R2");
    tick(2);
    wr(A_GSTS, 8'h01);
    expect_out(1, 1'b0, 1'b0, "R5");
    tick(2);
    wr(A_GENA, 8'h00);

    // R3 sleep command
    wr(A_SUP, 8'h02);
    wr(A_CMD, 8'h00);
    expect_out(1, 1'b0, 1'b0, "R3");
    rd(A_SUP, 8'h02, "R3");
    wr(A_CMD, 8'h01);
    expect_out(1, 1'b0, 1'b1, "R3");
    rd(A_SUP, 8'h03, "R3");
    tick(2);
    wr(A_SUP, 8'h01);
    expect_out(1, 1'b0, 1'b0, "R3");
    tick(2);
    rd(A_SUP, 8'h00, "R3");

    // R3 lock release command
    wr(A_SUP, 8'h08);
    wr(A_CMD, 8'h02);
    expect_out(1, 1'b0, 1'b1, "R3");
    rd(A_SUP, 8'h0C, "R3");
    tick(2);
    wr(A_SUP, 8'h04);
    expect_out(1, 1'b0, 1'b0, "R3");
    tick(2);

    // R3 system command register
    wr(A_SUP, 8'h40);
    wr(A_SMI, 8'hA5);
    expect_out(1, 1'b0, 1'b1, "R3");
    rd(A_SUP, 8'h60, "R3");
    tick(2);
    wr(A_SUP, 8'h20);
    expect_out(1, 1'b0, 1'b0, "R3");
    tick(2);
    rd(A_SUP, 8'h00, "R3");

    // R4 button blocked by routing select
    wr(A_CTL, 8'h16);
    sev();
    expect_out(1, 1'b0, 1'b0, "R4");
    expect_out(2, 1'b0, 1'b0, "R4");
    rd(A_SW, 8'h01, "R4");
    tick(2);
    wr(A_SW, 8'h01);
    rd(A_SW, 8'h00, "R4");

    // R4 button routed, own enable at 0
    wr(A_CTL, 8'h14);
    wr(A_SW, 8'h00);
    sev();
    expect_out(1, 1'b0, 1'b1, "R4");
    tick(2);

    // R6 status cleared, request held until level-clear
    wr(A_SW, 8'h01);
    expect_out(1, 1'b0, 1'b1, "R6");
    expect_out(3, 1'b0, 1'b1, "R6");
    tick(4);
    wr(A_CTL, 8'h1C);
    expect_out(1, 1'b0, 1'b1, "R6");
    expect_out(2, 1'b0, 1'b0, "R6");
    rd(A_CTL, 8'h1C, "R6");
    rd(A_CTL, 8'h14, "R6");
    tick(2);

    // R7 pulse mode
    wr(A_CTL, 8'h10);
    wr(A_GENB, 8'h60);
    gev(5);
    expect_out(1, 1'b0, 1'b1, "R7");
    expect_out(2, 1'b0, 1'b0, "R7");
    expect_out(3, 1'b0, 1'b0, "R7");
    tick(4);
    gev(6);
    expect_out(1, 1'b0, 1'b1, "R7");
    expect_out(2, 1'b0, 1'b0, "R7");
    tick(3);
    sev();
    expect_out(1, 1'b0, 1'b1, "R7");
    expect_out(2, 1'b0, 1'b0, "R7");
    tick(3);
    rd(A_GSTS, 8'h60, "R7");

    wr(A_GSTS, 8'hFF);
    wr(A_SW, 8'h01);
    tick(4);

    summary();
    $finish;
  end
endmodule